// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the per-port status and control state of one high-speed USB host root port. It owns three pieces of logic. The first decides whether the port belongs to the high-speed controller or to a companion controller, and follows a global configure flag. The second drives the port power switch, taking account of a power-control capability strap and of overcurrent. The third reports line state and raises wake events. Software reaches all of it through a single 32-bit register with a simple write strobe and a combinational readback.

After a device connects, software reads the two sampled bus lines while the port is still disabled. A low-speed device shows a K-state on the lines, and software then hands the port to the companion controller. Every other line code calls for a port reset. The block also decodes this choice for software on a small routing output. Wake enables for connect, disconnect and overcurrent are kept here. An enabled event produces a one-cycle wake request.

Top module: `usb_root_port_ctrl`

## Requirements
- R1: The companion-owner flag (register bit 0, output `companion_owned`) is 1 out of reset and is held at 1 in every cycle in which `cfg_flag` is 0, whatever software writes.
- R2: A 0-to-1 transition of `cfg_flag` clears the companion-owner flag on the next clock, even when software writes bit 0 = 1 in the same cycle. Otherwise, while `cfg_flag` is 1, a register write loads bit 0 into the flag.
- R3: With `pwr_ctl_cap` = 0, the power bit (register bit 1) and `pwr_switch_on` read 1 and writes to them have no effect. With `pwr_ctl_cap` = 1, the power bit resets to 0, is loaded from write bit 1, and drives `pwr_switch_on`.
- R4: With `pwr_ctl_cap` = 1 and the port powered, `ovc_in` = 1 turns the power bit off on the next clock. This takes priority over a simultaneous write of 1.
- R5: While the port is unpowered, the line-status field, the connect bit (bit 11) and the enable bit (bit 12) read 0, and `route_valid` is 0.
- R6: The line-status field is register bits [3:2], with bit 3 = D+ (`line_dp`) and bit 2 = D- (`line_dm`). It shows the lines only when the port is powered, `conn_sts` = 1 and `port_en_sts` = 0. Otherwise it reads 00.
- R7: `route_valid` is 1 exactly under the same condition as in R6. `route_release` is 1 only when `route_valid` is 1 and the line code is 01 (K-state). Codes 00 (SE0), 10 (J) and 11 give `route_release` = 0, which means reset the port.
- R8: The test-mode code (register bits [7:4], output `test_code`) resets to 0000. A write of codes 0000 to 0101 loads the code. A write of 0110 to 1111 is ignored, so the previous code remains.
- R9: The wake enables for overcurrent, disconnect and connect are register bits 8, 9 and 10. They reset to 0, are loaded on every write, and drive `wake_en_oc`, `wake_en_disc` and `wake_en_conn`.
- R10: `wake_request` is 1 for exactly one cycle, one clock after an enabled event. The events are a rising edge of `ovc_in`, a falling edge of `conn_sts`, and a rising edge of `conn_sts`. An event whose enable is 0 produces no request.
- R11: Register bits [31:13] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback |
| cfg_flag | input | 1 | Global configure flag |
| pwr_ctl_cap | input | 1 | Port power switch capability strap |
| ovc_in | input | 1 | Overcurrent detected |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| conn_sts | input | 1 | Current connect status |
| port_en_sts | input | 1 | Port enabled status |
| pwr_switch_on | output | 1 | Power switch control |
| companion_owned | output | 1 | Port owned by companion controller |
| test_code | output | 4 | Active test-mode code |
| wake_en_oc | output | 1 | Wake on overcurrent enabled |
| wake_en_disc | output | 1 | Wake on disconnect enabled |
| wake_en_conn | output | 1 | Wake on connect enabled |
| wake_request | output | 1 | One-cycle wake event pulse |
| route_valid | output | 1 | Line status is meaningful |
| route_release | output | 1 | 1 = release to companion, 0 = reset port |

## Verification
The bench targets the cycle where a configure-flag rise meets a software write of 1 to the owner bit. A design that lets software win leaves the port with the companion controller.

It writes reserved test codes after a legal one. A design that loads them exposes an illegal test mode.

It flips the capability strap around writes. A design that latches writes while the strap is 0 comes back powered when the strap returns.

It raises overcurrent together with a power-on write. A design that lets the write win keeps a faulted port powered.

It walks every line code under each connect/enable combination. A design with swapped D+/D- bits, or one that releases on J-state, routes low-speed devices wrongly.

Edge events are sent with their enables off. A design that does not gate on the enables issues spurious wake requests.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  localparam int TEST_W = 4;
  localparam logic [TEST_W-1:0] TEST_LAST = 4'd5;

  localparam int F_OWNER   = 0;
  localparam int F_POWER   = 1;
  localparam int F_LS_LO   = 2;
  localparam int F_LS_HI   = 3;
  localparam int F_TEST_LO = 4;
  localparam int F_TEST_HI = F_TEST_LO + TEST_W - 1;
  localparam int F_WK_LO   = 8;
  localparam int N_WAKE    = 3;
  localparam int F_WK_HI   = F_WK_LO + N_WAKE - 1;
  localparam int F_CONN    = 11;
  localparam int F_ENA     = 12;
  localparam int F_USED    = 13;

  // wake event index: 0 overcurrent rise, 1 disconnect, 2 connect
  localparam logic [N_WAKE-1:0] WAKE_RISE_MASK = 3'b101;

  typedef enum logic [1:0] {
    LS_SE0   = 2'b00,
    LS_K     = 2'b01,
    LS_J     = 2'b10,
    LS_UNDEF = 2'b11
  } line_state_e;

  function automatic logic test_code_ok(input logic [TEST_W-1:0] code);
    return code <= TEST_LAST;
  endfunction

  function automatic logic ls_wants_release(input logic [1:0] ls);
    return line_state_e'(ls) == LS_K;
  endfunction

  function automatic logic ls_meaningful(input logic powered, input logic conn,
                                         input logic enabled);
    return powered && conn && !enabled;
  endfunction

  function automatic logic [1:0] ls_sample(input logic dp, input logic dm,
                                           input logic valid);
    return valid ? {dp, dm} : 2'b00;
  endfunction
endpackage

// File: rtl/port_owner_ctrl.sv
module port_owner_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_flag,
  input  logic sw_wr,
  input  logic sw_val,
  output logic owner_q,
  output logic cfg_rise
);
  logic cfg_q;

  assign cfg_rise = cfg_flag && !cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 1'b0;
      owner_q <= 1'b1;
    end else begin
      cfg_q <= cfg_flag;
      if (!cfg_flag)      owner_q <= 1'b1;
      else if (cfg_rise)  owner_q <= 1'b0;
      else if (sw_wr)     owner_q <= sw_val;
    end
  end
endmodule

// File: rtl/port_power_ctrl.sv
module port_power_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic ovc,
  input  logic sw_wr,
  input  logic sw_val,
  output logic power_on,
  output logic ovc_trip
);
  logic pwr_q;

  assign power_on = cap ? pwr_q : 1'b1;
  assign ovc_trip = cap && pwr_q && ovc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pwr_q <= 1'b0;
    else if (ovc_trip)     pwr_q <= 1'b0;
    else if (sw_wr && cap) pwr_q <= sw_val;
  end
endmodule

// File: rtl/port_wake_detect.sv
module port_wake_detect #(
  parameter int N_EV = 3,
  parameter logic [N_EV-1:0] RISE_MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev_lvl,
  input  logic [N_EV-1:0] ev_en,
  output logic [N_EV-1:0] ev_hit,
  output logic            wake_pulse
);
  logic [N_EV-1:0] prev_q;

  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    if (RISE_MASK[i]) begin : g_rise
      assign ev_hit[i] = ev_lvl[i] && !prev_q[i];
    end else begin : g_fall
      assign ev_hit[i] = !ev_lvl[i] && prev_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      wake_pulse <= 1'b0;
    end else begin
      prev_q     <= ev_lvl;
      wake_pulse <= |(ev_hit & ev_en);
    end
  end
endmodule

// File: rtl/usb_root_port_ctrl.sv
module usb_root_port_ctrl
  import usb_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cfg_flag,
  input  logic              pwr_ctl_cap,
  input  logic              ovc_in,
  input  logic              line_dp,
  input  logic              line_dm,
  input  logic              conn_sts,
  input  logic              port_en_sts,
  output logic              pwr_switch_on,
  output logic              companion_owned,
  output logic [TEST_W-1:0] test_code,
  output logic              wake_en_oc,
  output logic              wake_en_disc,
  output logic              wake_en_conn,
  output logic              wake_request,
  output logic              route_valid,
  output logic              route_release
);
  logic              cfg_rise_w;
  logic              ovc_trip_w;
  logic [N_WAKE-1:0] wake_en_q;
  logic [N_WAKE-1:0] wake_hit_w;
  logic [TEST_W-1:0] test_q;
  logic [1:0]        ls_fld;
  logic              unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata[DATA_W-1:F_USED], reg_wdata[F_ENA:F_CONN],
                          reg_wdata[F_LS_HI:F_LS_LO]};

  port_owner_ctrl u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_flag (cfg_flag),
    .sw_wr    (reg_wr_en),
    .sw_val   (reg_wdata[F_OWNER]),
    .owner_q  (companion_owned),
    .cfg_rise (cfg_rise_w)
  );

  port_power_ctrl u_power (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (pwr_ctl_cap),
    .ovc      (ovc_in),
    .sw_wr    (reg_wr_en),
    .sw_val   (reg_wdata[F_POWER]),
    .power_on (pwr_switch_on),
    .ovc_trip (ovc_trip_w)
  );

  port_wake_detect #(
    .N_EV      (N_WAKE),
    .RISE_MASK (WAKE_RISE_MASK)
  ) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_lvl     ({conn_sts, conn_sts, ovc_in}),
    .ev_en      (wake_en_q),
    .ev_hit     (wake_hit_w),
    .wake_pulse (wake_request)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q    <= '0;
      wake_en_q <= '0;
    end else if (reg_wr_en) begin
      wake_en_q <= reg_wdata[F_WK_HI:F_WK_LO];
      if (test_code_ok(reg_wdata[F_TEST_HI:F_TEST_LO]))
        test_q <= reg_wdata[F_TEST_HI:F_TEST_LO];
    end
  end

  assign route_valid   = ls_meaningful(pwr_switch_on, conn_sts, port_en_sts);
  assign ls_fld        = ls_sample(line_dp, line_dm, route_valid);
  assign route_release = route_valid && ls_wants_release(ls_fld);

  assign test_code    = test_q;
  assign wake_en_oc   = wake_en_q[0];
  assign wake_en_disc = wake_en_q[1];
  assign wake_en_conn = wake_en_q[2];

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[F_OWNER]             = companion_owned;
    reg_rdata[F_POWER]             = pwr_switch_on;
    reg_rdata[F_LS_HI:F_LS_LO]     = ls_fld;
    reg_rdata[F_TEST_HI:F_TEST_LO] = test_q;
    reg_rdata[F_WK_HI:F_WK_LO]     = wake_en_q;
    reg_rdata[F_CONN]              = conn_sts && pwr_switch_on;
    reg_rdata[F_ENA]               = port_en_sts && pwr_switch_on;
  end
endmodule

// File: rtl/usb_root_port_chk.sv
module usb_root_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        cfg_flag,
  input logic        cfg_rise_w,
  input logic        ovc_trip_w,
  input logic        pwr_ctl_cap,
  input logic        pwr_switch_on,
  input logic        companion_owned,
  input logic [3:0]  test_code,
  input logic        wake_en_oc,
  input logic        wake_en_disc,
  input logic        wake_en_conn,
  input logic        wake_request,
  input logic        route_valid,
  input logic        route_release
);
  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> companion_owned); // R1
  AST_OWNER_CFG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rise_w |=> !companion_owned); // R2
  AST_POWER_NOCAP: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ctl_cap |-> pwr_switch_on); // R3
  AST_OVC_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_trip_w |=> (!pwr_switch_on || !pwr_ctl_cap)); // R4
  AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_switch_on |-> (reg_rdata[12:11] == 2'b00 && reg_rdata[3:2] == 2'b00 && !route_valid)); // R5
  AST_RELEASE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    route_release |-> (route_valid && reg_rdata[3:2] == 2'b01)); // R7
  AST_TEST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    test_code <= 4'd5); // R8
  AST_WAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_request |-> $past(wake_en_oc || wake_en_disc || wake_en_conn)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:13] == '0); // R11
endmodule

bind usb_root_port_ctrl usb_root_port_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .reg_rdata       (reg_rdata),
  .cfg_flag        (cfg_flag),
  .cfg_rise_w      (cfg_rise_w),
  .ovc_trip_w      (ovc_trip_w),
  .pwr_ctl_cap     (pwr_ctl_cap),
  .pwr_switch_on   (pwr_switch_on),
  .companion_owned (companion_owned),
  .test_code       (test_code),
  .wake_en_oc      (wake_en_oc),
  .wake_en_disc    (wake_en_disc),
  .wake_en_conn    (wake_en_conn),
  .wake_request    (wake_request),
  .route_valid     (route_valid),
  .route_release   (route_release)
);

// File: tb/usb_root_port_ctrl_tb_top.sv
module usb_root_port_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  // {conn, en, dp, dm} -> {route_valid, route_release, ls[1:0]}, port powered
  localparam logic [7:0] VEC [9] = '{
    8'b0000_0000, 8'b0001_0000, 8'b0110_0000, 8'b0111_0000,
    8'b1000_1000, 8'b1001_1101, 8'b1010_1010, 8'b1011_1011,
    8'b1101_0000
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr_en = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_flag = 0, pwr_ctl_cap = 1, ovc_in = 0;
  logic        line_dp = 0, line_dm = 0, conn_sts = 0, port_en_sts = 0;
  logic        pwr_switch_on, companion_owned;
  logic [3:0]  test_code;
  logic        wake_en_oc, wake_en_disc, wake_en_conn, wake_request;
  logic        route_valid, route_release;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_root_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_flag(cfg_flag), .pwr_ctl_cap(pwr_ctl_cap),
    .ovc_in(ovc_in), .line_dp(line_dp), .line_dm(line_dm), .conn_sts(conn_sts),
    .port_en_sts(port_en_sts), .pwr_switch_on(pwr_switch_on),
    .companion_owned(companion_owned), .test_code(test_code),
    .wake_en_oc(wake_en_oc), .wake_en_disc(wake_en_disc),
    .wake_en_conn(wake_en_conn), .wake_request(wake_request),
    .route_valid(route_valid), .route_release(route_release)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1; reg_wdata = d;
    step();
    reg_wr_en = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // reset state
    chk("R1 reset owner", {31'b0, companion_owned}, 32'h1);
    chk("R11 reset readback", reg_rdata, 32'h1);
    chk("R8 reset test", {28'b0, test_code}, 32'h0);
    chk("R9 reset wake en", {29'b0, wake_en_conn, wake_en_disc, wake_en_oc}, 32'h0);
    chk("R10 reset wake", {31'b0, wake_request}, 32'h0);

    // R1: write 0 while cfg_flag is 0
    wr(32'h0);
    chk("R1 held by cfg 0", {31'b0, companion_owned}, 32'h1);

    // R2
    cfg_flag = 1; step();
    chk("R2 cfg rise clears", {31'b0, companion_owned}, 32'h0);
    wr(32'h1);
    chk("R2 sw write 1", {31'b0, companion_owned}, 32'h1);
    wr(32'h0);
    chk("R2 sw write 0", {31'b0, companion_owned}, 32'h0);
    cfg_flag = 0; step();
    chk("R1 cfg low sets", {31'b0, companion_owned}, 32'h1);
    cfg_flag = 1; wr(32'h1);
    chk("R2 rise beats write", {31'b0, companion_owned}, 32'h0);

    // R3
    wr(32'h2);
    chk("R3 power on", {31'b0, pwr_switch_on}, 32'h1);
    chk("R3 power readback", {31'b0, reg_rdata[1]}, 32'h1);
    wr(32'h0);
    chk("R3 power off", {31'b0, pwr_switch_on}, 32'h0);
    pwr_ctl_cap = 0; #1;
    chk("R3 no cap powered", {31'b0, pwr_switch_on}, 32'h1);
    wr(32'h0);
    chk("R3 no cap write ignored", {31'b0, reg_rdata[1]}, 32'h1);
    wr(32'h2);
    pwr_ctl_cap = 1; #1;
    chk("R3 no cap write not latched", {31'b0, pwr_switch_on}, 32'h0);

    // R4
    wr(32'h2);
    ovc_in = 1; wr(32'h2);
    chk("R4 overcurrent cuts power", {31'b0, pwr_switch_on}, 32'h1 ^ 32'h1);
    ovc_in = 0; step();
    pwr_ctl_cap = 0; ovc_in = 1; step(); step();
    chk("R4 no cap stays powered", {31'b0, pwr_switch_on}, 32'h1);
    ovc_in = 0; pwr_ctl_cap = 1; step();

    // R5: unpowered, device present and not enabled
    conn_sts = 1; port_en_sts = 1; line_dp = 1; #1;
    chk("R5 unpowered status", {29'b0, reg_rdata[12:11], route_valid}, 32'h0);
    port_en_sts = 0; #1;
    chk("R5 unpowered line", {29'b0, reg_rdata[3:2], route_valid}, 32'h0);
    conn_sts = 0; step();

    // R6/R7 table, strap 0 keeps port powered
    pwr_ctl_cap = 0;
    for (int i = 0; i < 9; i++) begin
      {conn_sts, port_en_sts, line_dp, line_dm} = VEC[i][7:4];
      #1;
      chk("R6 line field", {30'b0, reg_rdata[3:2]}, {30'b0, VEC[i][1:0]});
      chk("R7 route", {30'b0, route_valid, route_release}, {30'b0, VEC[i][3:2]});
    end
    conn_sts = 0; port_en_sts = 0; line_dp = 0; line_dm = 0;
    step(); step();

    // R8
    wr(32'h30);
    chk("R8 legal code", {28'b0, test_code}, 32'h3);
    wr(32'h90);
    chk("R8 reserved ignored", {28'b0, test_code}, 32'h3);
    wr(32'h50);
    chk("R8 last legal", {28'b0, test_code}, 32'h5);
    wr(32'h60);
    chk("R8 first reserved", {28'b0, reg_rdata[7:4]}, 32'h5);
    wr(32'h0);
    chk("R8 back to off", {28'b0, test_code}, 32'h0);

    // R9 / R11
    wr(32'hFFFF_FF0F);
    chk("R9 wake enables", {29'b0, wake_en_conn, wake_en_disc, wake_en_oc}, 32'h7);
    chk("R11 reserved zero", reg_rdata & 32'hFFFF_E000, 32'h0);
    wr(32'h0);

    // R10
    conn_sts = 1; step();
    chk("R10 disabled connect", {31'b0, wake_request}, 32'h0);
    conn_sts = 0; step();
    wr(32'h400);
    conn_sts = 1; step();
    chk("R10 connect pulse", {31'b0, wake_request}, 32'h1);
    step();
    chk("R10 one cycle", {31'b0, wake_request}, 32'h0);
    conn_sts = 0; step();
    chk("R10 disc disabled", {31'b0, wake_request}, 32'h0);
    wr(32'h200);
    conn_sts = 1; step(); step();
    conn_sts = 0; step();
    chk("R10 disconnect pulse", {31'b0, wake_request}, 32'h1);
    ovc_in = 1; step();
    chk("R10 ovc disabled", {31'b0, wake_request}, 32'h0);
    ovc_in = 0; wr(32'h100);
    ovc_in = 1; step();
    chk("R10 ovc pulse", {31'b0, wake_request}, 32'h1);
    ovc_in = 0; step(); step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule